// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block is a hardware state machine that takes one processor core of a small cluster from powered-off and held in reset to running. A single-cycle start request carries a core index and a boot address. While it runs, the block drives per-core control vectors toward the cluster: reset control, L1-cache reset, external-debug enable, power-off gating and an 8-bit power clamp. It finishes by raising a one-cycle completion pulse.

The recipe has a fixed order. First the boot address is captured. Then the chosen core and its L1 cache are held in reset and debug access to that core is blocked. Next the clamp is stepped down to zero, one shift per clock. After a long settle wait the power-off gating for the core is removed, and after a short settle wait the core's reset is released. Debug access is restored last. Only one bring-up can run at a time. Settle waits are counted in clock cycles, derived from the clock frequency parameter.

Top module: `core_pwrup_seq`

## Requirements
- R1: After reset the boot address output is 0. Every core's 2-bit reset field is 00 (held). All L1 reset bits, debug-enable bits, `busy_o` and `done_o` are 0. All gating bits are 1 and every clamp byte is 0xFF.
- R2: A start seen at a clock edge while idle captures `boot_addr_i` and `core_idx_i`. The new boot address is visible after that edge, and `busy_o` is 1 from then until the sequence ends.
- R3: Counting the start edge as edge 0, the chosen core's reset field becomes 00 after edge 1, its L1 reset bit becomes 0 after edge 2, and its debug-enable bit becomes 0 after edge 3. The L1 reset bit stays 0 once the sequence ends.
- R4: After edges 4 through 12 the chosen core's clamp byte takes the values 0xFF >> i for i = 0..8, one value per cycle, ending at 0x00.
- R5: The long wait lasts LONG_WAIT_MS milliseconds, that is LONG_WAIT_MS*CLK_HZ/1000 = L cycles. After edge 13+L the core's gating bit becomes 0. It is never cleared while the clamp byte is nonzero.
- R6: The short wait lasts S = SHORT_WAIT_MS*CLK_HZ/1000 cycles. After edge 14+L+S the core's reset field becomes 11 (released).
- R7: After edge 15+L+S the core's debug-enable bit becomes 1, `done_o` is 1 for exactly that one cycle, and `busy_o` is 0 in that same cycle. Debug enable never rises while the core's reset field is not 11.
- R8: A start seen while `busy_o` is 1 is ignored. The boot address, the chosen core and the timing of the running sequence are unchanged.
- R9: No bit belonging to a core other than the chosen one ever changes.
- R10: Core n owns reset bits [2n+1:2n], clamp bits [8n+7:8n], and bit n of the L1-reset, debug-enable and gating vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled at the clock edge |
| core_idx_i | input | IDX_W (2) | Index of the core to bring up |
| boot_addr_i | input | ADDR_W (32) | Boot address to capture |
| boot_addr_o | output | ADDR_W (32) | Shared boot-address register |
| core_rst_o | output | 2*NUM_CORES (8) | Per-core 2-bit reset fields, 00 held, 11 released |
| l1_rst_n_o | output | NUM_CORES (4) | Per-core L1 reset, 0 holds the cache in reset |
| dbg_en_o | output | NUM_CORES (4) | Per-core external-debug enable |
| pwr_gate_o | output | NUM_CORES (4) | Per-core power-off gating, 1 gated |
| clamp_o | output | CLAMP_W*NUM_CORES (32) | Per-core power clamp bytes |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A reference model in the bench keeps a shadow of every vector and predicts each field change with its exact cycle offset. Fresh cores are brought up in a scrambled order, which separates correct field placement from index mix-ups. A core is then brought up again after it is already running. Because writes that leave a value unchanged do not show up, the rerun exposes reset, debug and clamp writes that the first pass hides. Further runs hold start for two cycles, send a mid-sequence start carrying another core and another address, and reuse the previous boot address. These show that a start arriving while busy touches nothing, and that only the chosen core's bits move.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST_HOLD,
      ST_L1_HOLD,
      ST_DBG_OFF,
      ST_RAMP,
      ST_WAIT_LONG,
      ST_UNGATE,
      ST_WAIT_SHORT,
      ST_RST_REL,
      ST_DBG_ON
   } seq_state_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_RST_HOLD,
      OP_L1_HOLD,
      OP_DBG_OFF,
      OP_CLAMP,
      OP_UNGATE,
      OP_RST_REL,
      OP_DBG_ON
   } slot_op_e;

   localparam logic [1:0] RST_FIELD_HOLD = 2'b00;
   localparam logic [1:0] RST_FIELD_RUN  = 2'b11;

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (run_i) cnt_q <= cnt_q + CNT_W'(1);
      else            cnt_q <= '0;
   end

   assign expire_o = run_i && (cnt_q == len_i - CNT_W'(1));

   // R5 R6: a wait never overruns its length
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q < len_i));

endmodule

// File: rtl/pwrup_core_slot.sv
module pwrup_core_slot
   import core_pwrup_pkg::*;
#(
   parameter int CLAMP_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_i,
   input  slot_op_e           op_i,
   input  logic [CLAMP_W-1:0] clamp_val_i,
   output logic [1:0]         rst_ctrl_o,
   output logic               l1_rst_n_o,
   output logic               dbg_en_o,
   output logic               pwr_gate_o,
   output logic [CLAMP_W-1:0] clamp_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_ctrl_o <= RST_FIELD_HOLD;
         l1_rst_n_o <= 1'b0;
         dbg_en_o   <= 1'b0;
         pwr_gate_o <= 1'b1;
         clamp_o    <= '1;
      end else if (sel_i) begin
         unique case (op_i)
            OP_RST_HOLD: rst_ctrl_o <= RST_FIELD_HOLD;
            OP_L1_HOLD:  l1_rst_n_o <= 1'b0;
            OP_DBG_OFF:  dbg_en_o   <= 1'b0;
            OP_CLAMP:    clamp_o    <= clamp_val_i;
            OP_UNGATE:   pwr_gate_o <= 1'b0;
            OP_RST_REL:  rst_ctrl_o <= RST_FIELD_RUN;
            OP_DBG_ON:   dbg_en_o   <= 1'b1;
            default:     ;
         endcase
      end
   end

   // R9
   foreign_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> $stable({rst_ctrl_o, l1_rst_n_o, dbg_en_o, pwr_gate_o, clamp_o}));

   // R7
   dbg_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_en_o) |-> (rst_ctrl_o == RST_FIELD_RUN));

   // R5
   ungate_after_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_gate_o) |-> (clamp_o == '0));

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
   import core_pwrup_pkg::*;
#(
   parameter int NUM_CORES     = 4,
   parameter int ADDR_W        = 32,
   parameter int CLAMP_W       = 8,
   parameter int CLK_HZ        = 24_000_000,
   parameter int LONG_WAIT_MS  = 10,
   parameter int SHORT_WAIT_MS = 1,
   localparam int IDX_W        = $clog2(NUM_CORES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [IDX_W-1:0]             core_idx_i,
   input  logic [ADDR_W-1:0]            boot_addr_i,
   output logic [ADDR_W-1:0]            boot_addr_o,
   output logic [2*NUM_CORES-1:0]       core_rst_o,
   output logic [NUM_CORES-1:0]         l1_rst_n_o,
   output logic [NUM_CORES-1:0]         dbg_en_o,
   output logic [NUM_CORES-1:0]         pwr_gate_o,
   output logic [CLAMP_W*NUM_CORES-1:0] clamp_o,
   output logic                         busy_o,
   output logic                         done_o
);

   localparam int CYC_PER_MS = CLK_HZ / 1000;
   localparam int LONG_CYC   = CYC_PER_MS * LONG_WAIT_MS;
   localparam int SHORT_CYC  = CYC_PER_MS * SHORT_WAIT_MS;
   localparam int MAX_CYC    = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int CNT_W      = $clog2(MAX_CYC + 1);
   localparam int STEP_W     = $clog2(CLAMP_W + 1);
   localparam logic [CNT_W-1:0]  LONG_LEN  = CNT_W'(LONG_CYC);
   localparam logic [CNT_W-1:0]  SHORT_LEN = CNT_W'(SHORT_CYC);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CLAMP_W);

   // elaboration-time parameter checks
   if (NUM_CORES < 2 || (1 << IDX_W) != NUM_CORES) begin : g_bad_cores
      $error("NUM_CORES must be a power of two, at least 2");
   end
   if (CLAMP_W < 1) begin : g_bad_clamp
      $error("CLAMP_W must be at least 1");
   end
   if (CLK_HZ < 1000 || LONG_WAIT_MS < 1 || SHORT_WAIT_MS < 1) begin : g_bad_wait
      $error("settle waits must be at least one cycle");
   end

   seq_state_e          state_q;
   logic [IDX_W-1:0]    sel_q;
   logic [STEP_W-1:0]   step_q;
   logic                timer_run;
   logic                timer_expire;
   logic [CNT_W-1:0]    timer_len;
   slot_op_e            op;
   logic [CLAMP_W-1:0]  clamp_val;

   assign busy_o    = (state_q != ST_IDLE);
   assign timer_run = (state_q == ST_WAIT_LONG) || (state_q == ST_WAIT_SHORT);
   assign timer_len = (state_q == ST_WAIT_LONG) ? LONG_LEN : SHORT_LEN;
   assign clamp_val = {CLAMP_W{1'b1}} >> step_q;

   always_comb begin
      unique case (state_q)
         ST_RST_HOLD: op = OP_RST_HOLD;
         ST_L1_HOLD:  op = OP_L1_HOLD;
         ST_DBG_OFF:  op = OP_DBG_OFF;
         ST_RAMP:     op = OP_CLAMP;
         ST_UNGATE:   op = OP_UNGATE;
         ST_RST_REL:  op = OP_RST_REL;
         ST_DBG_ON:   op = OP_DBG_ON;
         default:     op = OP_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sel_q       <= '0;
         step_q      <= '0;
         boot_addr_o <= '0;
         done_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               sel_q       <= core_idx_i;
               boot_addr_o <= boot_addr_i;
               state_q     <= ST_RST_HOLD;
            end
            ST_RST_HOLD: state_q <= ST_L1_HOLD;
            ST_L1_HOLD:  state_q <= ST_DBG_OFF;
            ST_DBG_OFF: begin
               step_q  <= '0;
               state_q <= ST_RAMP;
            end
            ST_RAMP: begin
               if (step_q == LAST_STEP) begin
                  step_q  <= '0;
                  state_q <= ST_WAIT_LONG;
               end else begin
                  step_q <= step_q + STEP_W'(1);
               end
            end
            ST_WAIT_LONG:  if (timer_expire) state_q <= ST_UNGATE;
            ST_UNGATE:     state_q <= ST_WAIT_SHORT;
            ST_WAIT_SHORT: if (timer_expire) state_q <= ST_RST_REL;
            ST_RST_REL:    state_q <= ST_DBG_ON;
            ST_DBG_ON: begin
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   pwrup_wait_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (timer_run),
      .len_i    (timer_len),
      .expire_o (timer_expire)
   );

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
      pwrup_core_slot #(.CLAMP_W(CLAMP_W)) i_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .sel_i       (sel_q == IDX_W'(g)),
         .op_i        (op),
         .clamp_val_i (clamp_val),
         .rst_ctrl_o  (core_rst_o[2*g +: 2]),
         .l1_rst_n_o  (l1_rst_n_o[g]),
         .dbg_en_o    (dbg_en_o[g]),
         .pwr_gate_o  (pwr_gate_o[g]),
         .clamp_o     (clamp_o[CLAMP_W*g +: CLAMP_W])
      );
   end

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(boot_addr_o));

   // R8
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(sel_q));

endmodule

// File: tb/test_core_pwrup_seq.sv
`timescale 1ns/1ps
module test_core_pwrup_seq;

   localparam int CLK_HZ = 125_000;           // reduced-scale timing
   localparam int L = (CLK_HZ / 1000) * 10;
   localparam int S = (CLK_HZ / 1000) * 1;

   localparam logic [3:0] K_BOOT = 4'd0, K_RST = 4'd1, K_L1 = 4'd2, K_DBG = 4'd3,
                          K_GATE = 4'd4, K_CLAMP = 4'd5, K_DONE = 4'd6;

   typedef struct packed {
      logic [3:0]  kind;
      logic [1:0]  core;
      logic [31:0] val;
      logic [31:0] ofs;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  core_idx_i = '0;
   logic [31:0] boot_addr_i = '0;
   logic [31:0] boot_addr_o;
   logic [7:0]  core_rst_o;
   logic [3:0]  l1_rst_n_o, dbg_en_o, pwr_gate_o;
   logic [31:0] clamp_o;
   logic        busy_o, done_o;

   int  checks = 0;
   int  failures = 0;
   int  cyc = 0;
   int  t0 = 0;
   bit  finished = 0;
   ev_t exp_q[$];

   // shadow model of the vectors
   logic [1:0]  s_rst[4];
   logic        s_l1[4], s_dbg[4], s_gate[4];
   logic [7:0]  s_clamp[4];
   logic [31:0] s_boot;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   core_pwrup_seq #(.CLK_HZ(CLK_HZ)) i_core_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_idx_i(core_idx_i),
      .boot_addr_i(boot_addr_i), .boot_addr_o(boot_addr_o), .core_rst_o(core_rst_o),
      .l1_rst_n_o(l1_rst_n_o), .dbg_en_o(dbg_en_o), .pwr_gate_o(pwr_gate_o),
      .clamp_o(clamp_o), .busy_o(busy_o), .done_o(done_o)
   );

   function automatic string req_of(ev_t e);
      case (e.kind)
         K_BOOT:  return "R2";
         K_RST:   return (e.val == 0) ? "R3" : "R6";
         K_L1:    return "R3";
         K_DBG:   return (e.val == 0) ? "R3" : "R7";
         K_GATE:  return "R5";
         K_CLAMP: return "R4";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(input logic [3:0] k, input int c, input logic [31:0] v, input int o);
      ev_t e;
      e.kind = k; e.core = 2'(c); e.val = v; e.ofs = 32'(o);
      exp_q.push_back(e);
   endtask

   // monitor: every field change becomes an event, compared against the queue
   logic [31:0] p_boot;
   logic [7:0]  p_rst;
   logic [3:0]  p_l1, p_dbg, p_gate;
   logic [31:0] p_clamp;

   task automatic observe(input ev_t got);
      ev_t e;
      checks++;
      if (exp_q.size() == 0) begin
         failures++;
         $display("FAIL R8 R9 unexpected kind=%0d core=%0d actual=%0h@%0d expected=none",
                  got.kind, got.core, got.val, got.ofs);
      end else begin
         e = exp_q.pop_front();
         if (got != e) begin
            failures++;
            $display("FAIL %s%s kind=%0d core=%0d actual=%0h@%0d expected kind=%0d core=%0d %0h@%0d",
                     req_of(e), (got.core != e.core) ? " R10" : "", got.kind, got.core,
                     got.val, got.ofs, e.kind, e.core, e.val, e.ofs);
         end
      end
   endtask

   always @(negedge clk) begin
      ev_t g;
      if (rst_n) begin
         g.ofs = 32'(cyc - t0);
         if (boot_addr_o != p_boot) begin
            g.kind = K_BOOT; g.core = 0; g.val = boot_addr_o; observe(g);
         end
         for (int c = 0; c < 4; c++) begin
            g.core = 2'(c);
            if (core_rst_o[2*c +: 2] != p_rst[2*c +: 2]) begin
               g.kind = K_RST; g.val = 32'(core_rst_o[2*c +: 2]); observe(g);
            end
            if (l1_rst_n_o[c] != p_l1[c]) begin
               g.kind = K_L1; g.val = 32'(l1_rst_n_o[c]); observe(g);
            end
            if (dbg_en_o[c] != p_dbg[c]) begin
               g.kind = K_DBG; g.val = 32'(dbg_en_o[c]); observe(g);
            end
            if (pwr_gate_o[c] != p_gate[c]) begin
               g.kind = K_GATE; g.val = 32'(pwr_gate_o[c]); observe(g);
            end
            if (clamp_o[8*c +: 8] != p_clamp[8*c +: 8]) begin
               g.kind = K_CLAMP; g.val = 32'(clamp_o[8*c +: 8]); observe(g);
            end
         end
         if (done_o) begin
            g.kind = K_DONE; g.core = 0; g.val = 32'(busy_o); observe(g);
         end
      end
      p_boot = boot_addr_o; p_rst = core_rst_o; p_l1 = l1_rst_n_o;
      p_dbg = dbg_en_o; p_gate = pwr_gate_o; p_clamp = clamp_o;
   end

   // driver: predicts the recipe on the shadow, then issues the start
   task automatic bring_up(input int core, input logic [31:0] addr,
                           input bit poke, input bit hold2);
      if (addr != s_boot) expect_ev(K_BOOT, 0, addr, 1);
      s_boot = addr;
      if (s_rst[core] != 2'b00) expect_ev(K_RST, core, 0, 2);
      s_rst[core] = 2'b00;
      if (s_l1[core] != 1'b0) expect_ev(K_L1, core, 0, 3);
      s_l1[core] = 1'b0;
      if (s_dbg[core] != 1'b0) expect_ev(K_DBG, core, 0, 4);
      s_dbg[core] = 1'b0;
      for (int i = 0; i <= 8; i++) begin
         if ((8'hFF >> i) != s_clamp[core]) expect_ev(K_CLAMP, core, 32'(8'hFF >> i), 5 + i);
         s_clamp[core] = 8'hFF >> i;
      end
      if (s_gate[core] != 1'b0) expect_ev(K_GATE, core, 0, 14 + L);
      s_gate[core] = 1'b0;
      expect_ev(K_RST, core, 3, 15 + L + S);
      s_rst[core] = 2'b11;
      expect_ev(K_DBG, core, 1, 16 + L + S);
      s_dbg[core] = 1'b1;
      expect_ev(K_DONE, 0, 0, 16 + L + S);

      @(negedge clk);
      start_i = 1'b1; core_idx_i = 2'(core); boot_addr_i = addr; t0 = cyc;
      @(negedge clk);
      if (hold2) begin
         // R8: start held into a busy cycle, with another core index
         core_idx_i = 2'(core + 1); boot_addr_i = 32'hBAD0_0001;
         @(negedge clk);
      end
      start_i = 1'b0;
      if (poke) begin
         repeat (30) @(negedge clk);
         check(busy_o == 1'b1, "R2", "busy mid-sequence", 64'(busy_o), 64'd1);
         start_i = 1'b1; core_idx_i = 2'(core + 2); boot_addr_i = 32'hDEAD_BEEF;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         check(boot_addr_o == addr, "R8", "boot addr after busy start", 64'(boot_addr_o), 64'(addr));
      end
      while (!done_o) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int c = 0; c < 4; c++) begin
         s_rst[c] = 2'b00; s_l1[c] = 1'b0; s_dbg[c] = 1'b0;
         s_gate[c] = 1'b1; s_clamp[c] = 8'hFF;
      end
      s_boot = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(boot_addr_o == 0, "R1", "boot addr", 64'(boot_addr_o), 64'd0);
      check(core_rst_o == 8'h00, "R1", "reset fields", 64'(core_rst_o), 64'h00);
      check(l1_rst_n_o == 4'h0, "R1", "l1 reset", 64'(l1_rst_n_o), 64'h0);
      check(dbg_en_o == 4'h0, "R1", "debug enable", 64'(dbg_en_o), 64'h0);
      check(pwr_gate_o == 4'hF, "R1", "gating", 64'(pwr_gate_o), 64'hF);
      check(clamp_o == 32'hFFFF_FFFF, "R1", "clamps", 64'(clamp_o), 64'hFFFF_FFFF);
      check(!busy_o && !done_o, "R1", "busy/done", 64'({busy_o, done_o}), 64'd0);

      bring_up(2, 32'h4000_0100, 1'b1, 1'b0);
      bring_up(0, 32'h4000_0200, 1'b0, 1'b1);
      bring_up(3, 32'h4000_0300, 1'b0, 1'b0);
      bring_up(1, 32'h4000_0400, 1'b1, 1'b0);
      bring_up(2, 32'h4000_0500, 1'b0, 1'b0);   // rerun of a running core
      bring_up(0, 32'h4000_0500, 1'b0, 1'b0);   // same boot address again

      // R3: L1 reset bits stay cleared, R10 final packing
      check(l1_rst_n_o == 4'h0, "R3", "l1 reset kept", 64'(l1_rst_n_o), 64'h0);
      check(core_rst_o == 8'hFF && clamp_o == 0 && pwr_gate_o == 0 && dbg_en_o == 4'hF,
            "R10", "final vectors", 64'({core_rst_o, pwr_gate_o, dbg_en_o}), 64'hFF0F);
      check(exp_q.size() == 0, "R7", "missing events", 64'(exp_q.size()), 64'd0);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL R7 watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule